// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Selective Status Update

This block is the 8-bit arithmetic and logic datapath of a small processor core. It takes two byte operands, an external carry bit and a 5-bit operation code. It returns the byte result combinationally in the same cycle, together with a write-back qualifier. A six-flag status byte sits beside the datapath. On each clock edge where the status write strobe is high, the status byte takes a new value.

Every operation has a fixed set of flags it is allowed to touch. Flags outside that set keep their stored value. This lets software interleave, for example, logical operations with a chain of multi-byte additions without losing the carry. The subtract-with-carry and compare-with-carry operations can only clear the zero flag. Because of this, a multi-byte comparison ends with a zero flag that is valid for the whole word.

Top module: `alu8_status`

## Requirements
- R1: After a synchronous active-high reset, the status byte is 0x00. Its layout is bit0 carry (C), bit1 zero (Z), bit2 negative (N), bit3 overflow (V), bit4 sign (S) and bit5 half-carry (H). Bits 7:6 always read 0.
- R2: Opcode 0 (add) gives a+b and opcode 1 (add with carry) gives a+b+carry_i. Both update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (result bit 7), Z (result zero) and S.
- R3: Opcode 2 (subtract) gives a-b and opcode 3 (subtract with carry) gives a-b-carry_i. Opcode 4 (compare) forms a-b and opcode 5 (compare with carry) forms a-b-carry_i. All four update C (borrow out of bit 7), H (borrow out of bit 3), V, N, Z and S.
- R4: For opcodes 3 and 5, the new Z is 1 only when the difference is zero and the stored Z is 1. Otherwise the new Z is 0.
- R5: Opcodes 4 and 5 drive wb_o low, because their result is not written back. Every other opcode from 0 to 18 drives wb_o high.
- R6: Opcodes 6 (AND), 7 (OR) and 8 (XOR) set Z and N from the result, force V to 0 and refresh S. They hold C and H.
- R7: Opcode 9 gives 0xFF-a, sets C to 1, forces V to 0 and updates Z, N and S. Opcode 10 gives 0x00-a and updates C, H, V, N, Z and S as a subtraction from zero.
- R8: Opcode 11 gives a+1 and opcode 12 gives a-1. Both update Z, N and S. V is set only for 0x7F+1 and for 0x80-1. C and H are held.
- R9: Opcode 13 shifts left and opcode 14 shifts right, each inserting 0. Opcode 15 rotates left and opcode 16 rotates right, each through carry_i. Opcode 17 shifts right and keeps bit 7. For all five, C is the bit shifted out, V = N xor C, and Z, N and S update. H is held.
- R10: Opcode 18 swaps the two nibbles of a and leaves every flag unchanged.
- R11: Whenever N or V is written, S is written as N xor V.
- R12: When status_we_i is low, the status byte does not change. result_o follows the inputs in the same cycle.
- R13: Opcodes 19 to 31 pass a through to result_o, drive wb_o low and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination side) |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry input for carry-using operations |
| status_we_i | input | 1 | Status byte write strobe |
| result_o | output | 8 | Combinational result |
| wb_o | output | 1 | High when the result is meant to be written back |
| status_o | output | 8 | Stored status byte |

## Verification
Uniformly random operands separate the normal carry and overflow paths of each operation. A random write strobe and random unused opcodes show whether a flag that should be held was overwritten. Directed operands then reach the points that random draws rarely hit:
- 0x7F+1 and 0x80-1 for overflow;
- 0xFF+1 for carry, half-carry and zero together;
- 0x80 for negate;
- a two-byte compare chain whose low byte differs but whose high byte matches, which tells a sticky zero flag apart from one that is simply recomputed.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int DW   = 8;
    localparam int HW   = DW / 2;
    localparam int OPW  = 5;
    localparam int MSB  = DW - 1;

    localparam logic [OPW-1:0] OP_ADD  = 5'd0;
    localparam logic [OPW-1:0] OP_ADC  = 5'd1;
    localparam logic [OPW-1:0] OP_SUB  = 5'd2;
    localparam logic [OPW-1:0] OP_SBC  = 5'd3;
    localparam logic [OPW-1:0] OP_CMP  = 5'd4;
    localparam logic [OPW-1:0] OP_CPC  = 5'd5;
    localparam logic [OPW-1:0] OP_AND  = 5'd6;
    localparam logic [OPW-1:0] OP_OR   = 5'd7;
    localparam logic [OPW-1:0] OP_XOR  = 5'd8;
    localparam logic [OPW-1:0] OP_COM  = 5'd9;
    localparam logic [OPW-1:0] OP_NEG  = 5'd10;
    localparam logic [OPW-1:0] OP_INC  = 5'd11;
    localparam logic [OPW-1:0] OP_DEC  = 5'd12;
    localparam logic [OPW-1:0] OP_LSL  = 5'd13;
    localparam logic [OPW-1:0] OP_LSR  = 5'd14;
    localparam logic [OPW-1:0] OP_ROL  = 5'd15;
    localparam logic [OPW-1:0] OP_ROR  = 5'd16;
    localparam logic [OPW-1:0] OP_ASR  = 5'd17;
    localparam logic [OPW-1:0] OP_SWAP = 5'd18;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       h;
        logic       s;
        logic       v;
        logic       n;
        logic       z;
        logic       c;
    } flags_t;

    function automatic logic uses_adder(logic [OPW-1:0] op);
        return (op <= OP_CPC) || (op == OP_NEG);
    endfunction

    function automatic logic is_subtract(logic [OPW-1:0] op);
        return (op >= OP_SUB && op <= OP_CPC) || (op == OP_NEG);
    endfunction

    function automatic logic takes_carry(logic [OPW-1:0] op);
        return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic zero_chains(logic [OPW-1:0] op);
        return (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic is_logical(logic [OPW-1:0] op);
        return (op >= OP_AND) && (op <= OP_XOR);
    endfunction

    function automatic logic is_shift(logic [OPW-1:0] op);
        return (op >= OP_LSL) && (op <= OP_ASR);
    endfunction

    // Flags each operation may write; the rest are held.
    function automatic flags_t write_mask(logic [OPW-1:0] op);
        flags_t m;
        m = '0;
        if (uses_adder(op)) begin
            m.c = 1'b1; m.z = 1'b1; m.n = 1'b1; m.v = 1'b1; m.s = 1'b1; m.h = 1'b1;
        end else if (is_logical(op) || op == OP_INC || op == OP_DEC) begin
            m.z = 1'b1; m.n = 1'b1; m.v = 1'b1; m.s = 1'b1;
        end else if (op == OP_COM || is_shift(op)) begin
            m.c = 1'b1; m.z = 1'b1; m.n = 1'b1; m.v = 1'b1; m.s = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hout_o,
    output logic          ovf_o
);
    logic [DW:0] full;
    logic [HW:0] half;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, opa_i} - {1'b0, opb_i} - {{DW{1'b0}}, cin_i};
            half = {1'b0, opa_i[HW-1:0]} - {1'b0, opb_i[HW-1:0]} - {{HW{1'b0}}, cin_i};
        end else begin
            full = {1'b0, opa_i} + {1'b0, opb_i} + {{DW{1'b0}}, cin_i};
            half = {1'b0, opa_i[HW-1:0]} + {1'b0, opb_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        end
        sum_o  = full[DW-1:0];
        cout_o = full[DW];
        hout_o = half[HW];
        if (sub_i)
            ovf_o = (opa_i[MSB] != opb_i[MSB]) && (sum_o[MSB] != opa_i[MSB]);
        else
            ovf_o = (opa_i[MSB] == opb_i[MSB]) && (sum_o[MSB] != opa_i[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
module alu8_bitops
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           cin_i,
    output logic [DW-1:0]  res_o,
    output logic           cout_o,
    output logic           ovf_o
);
    always_comb begin
        res_o  = a_i;
        cout_o = 1'b0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  begin res_o = ~a_i; cout_o = 1'b1; end
            OP_INC:  res_o = a_i + {{(DW-1){1'b0}}, 1'b1};
            OP_DEC:  res_o = a_i - {{(DW-1){1'b0}}, 1'b1};
            OP_LSL:  begin res_o = {a_i[DW-2:0], 1'b0};   cout_o = a_i[MSB]; end
            OP_LSR:  begin res_o = {1'b0, a_i[DW-1:1]};   cout_o = a_i[0];   end
            OP_ROL:  begin res_o = {a_i[DW-2:0], cin_i};  cout_o = a_i[MSB]; end
            OP_ROR:  begin res_o = {cin_i, a_i[DW-1:1]};  cout_o = a_i[0];   end
            OP_ASR:  begin res_o = {a_i[MSB], a_i[DW-1:1]}; cout_o = a_i[0]; end
            OP_SWAP: res_o = {a_i[HW-1:0], a_i[DW-1:HW]};
            default: res_o = a_i;
        endcase

        if (is_shift(op_i))
            ovf_o = res_o[MSB] ^ cout_o;
        else if (op_i == OP_INC)
            ovf_o = (res_o == {1'b1, {(DW-1){1'b0}}});
        else if (op_i == OP_DEC)
            ovf_o = (res_o == {1'b0, {(DW-1){1'b1}}});
        else
            ovf_o = 1'b0;
    end
endmodule

// File: rtl/alu8_flagcalc.sv
`timescale 1ns/1ps
module alu8_flagcalc
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  res_i,
    input  logic           arith_c_i,
    input  logic           arith_h_i,
    input  logic           arith_v_i,
    input  logic           bit_c_i,
    input  logic           bit_v_i,
    input  flags_t         cur_i,
    output flags_t         next_o
);
    flags_t cand;
    flags_t mask;
    logic   res_zero;

    always_comb begin
        res_zero = (res_i == '0);
        cand     = '0;
        if (uses_adder(op_i)) begin
            cand.c = arith_c_i;
            cand.h = arith_h_i;
            cand.v = arith_v_i;
        end else begin
            cand.c = bit_c_i;
            cand.v = bit_v_i;
        end
        cand.n = res_i[MSB];
        cand.z = zero_chains(op_i) ? (res_zero & cur_i.z) : res_zero;
        cand.s = cand.n ^ cand.v;
        mask   = write_mask(op_i);
        next_o = (cand & mask) | (cur_i & ~mask);
        next_o.rsvd = 2'b00;
    end
endmodule

// File: rtl/alu8_status.sv
`timescale 1ns/1ps
module alu8_status
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           carry_i,
    input  logic           status_we_i,
    output logic [DW-1:0]  result_o,
    output logic           wb_o,
    output logic [7:0]     status_o
);
    logic [DW-1:0] add_a, add_b, add_res, bit_res;
    logic          add_c, add_h, add_v, bit_c, bit_v;
    flags_t        stat_q, stat_d;

    always_comb begin
        add_a = (op_i == OP_NEG) ? '0  : a_i;
        add_b = (op_i == OP_NEG) ? a_i : b_i;
    end

    alu8_addsub u_addsub (
        .opa_i  (add_a),
        .opb_i  (add_b),
        .cin_i  (takes_carry(op_i) & carry_i),
        .sub_i  (is_subtract(op_i)),
        .sum_o  (add_res),
        .cout_o (add_c),
        .hout_o (add_h),
        .ovf_o  (add_v)
    );

    alu8_bitops u_bitops (
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (carry_i),
        .res_o  (bit_res),
        .cout_o (bit_c),
        .ovf_o  (bit_v)
    );

    assign result_o = uses_adder(op_i) ? add_res : bit_res;
    assign wb_o     = (op_i <= OP_SWAP) && (op_i != OP_CMP) && (op_i != OP_CPC);

    alu8_flagcalc u_flagcalc (
        .op_i      (op_i),
        .res_i     (result_o),
        .arith_c_i (add_c),
        .arith_h_i (add_h),
        .arith_v_i (add_v),
        .bit_c_i   (bit_c),
        .bit_v_i   (bit_v),
        .cur_i     (stat_q),
        .next_o    (stat_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else if (status_we_i)
            stat_q <= stat_d;
    end

    assign status_o = stat_q;

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status_o[7:6] == 2'b00);

    assert_chain_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (status_we_i && zero_chains(op_i) && !status_o[1]) |=> !status_o[1]);

    assert_logic_holds_ch_R6: assert property (@(posedge clk) disable iff (rst)
        (status_we_i && is_logical(op_i)) |=>
        (status_o[0] == $past(status_o[0])) && (status_o[5] == $past(status_o[5])) && !status_o[3]);

    assert_com_sets_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (status_we_i && op_i == OP_COM) |=> status_o[0] && !status_o[3]);

    assert_incdec_holds_c_R8: assert property (@(posedge clk) disable iff (rst)
        (status_we_i && (op_i == OP_INC || op_i == OP_DEC)) |=>
        (status_o[0] == $past(status_o[0])) && (status_o[5] == $past(status_o[5])));

    assert_swap_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (status_we_i && op_i == OP_SWAP) |=> $stable(status_o));

    assert_sign_relation_R11: assert property (@(posedge clk) disable iff (rst)
        status_o[4] == (status_o[2] ^ status_o[3]));

    assert_hold_without_we_R12: assert property (@(posedge clk) disable iff (rst)
        !status_we_i |=> $stable(status_o));

    assert_unused_code_R13: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_SWAP) |=> $stable(status_o));
endmodule

// File: tb/alu8_status_bench.sv
`timescale 1ns/1ps
module alu8_status_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic       ci = 1'b0, we = 1'b0;
    logic [7:0] result;
    logic       wb;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_stat = 8'h00;

    always #2.5 clk = ~clk;

    alu8_status u_alu8_status (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .carry_i(ci),
        .status_we_i(we), .result_o(result), .wb_o(wb), .status_o(status)
    );

    function automatic string req_of(logic [4:0] o);
        if (o <= 5'd1) return "R2";
        if (o == 5'd3 || o == 5'd5) return "R4";
        if (o <= 5'd5) return "R3";
        if (o <= 5'd8) return "R6";
        if (o <= 5'd10) return "R7";
        if (o <= 5'd12) return "R8";
        if (o <= 5'd17) return "R9";
        if (o == 5'd18) return "R10";
        return "R13";
    endfunction

    // Reference model: returns {wb, result, new status}
    function automatic logic [16:0] model(logic [4:0] o, logic [7:0] x, logic [7:0] y,
                                          logic cin, logic [7:0] st);
        logic [7:0] r;
        logic c, z, n, v, s, h, cc, w;
        logic wc, wz, wnv, wh;
        c = st[0]; z = st[1]; n = st[2]; v = st[3]; s = st[4]; h = st[5];
        wc = 0; wz = 0; wnv = 0; wh = 0; r = x; w = 1'b1;
        cc = (o == 5'd1 || o == 5'd3 || o == 5'd5) ? cin : 1'b0;
        case (o)
            5'd0, 5'd1: begin
                r = x + y + {7'd0, cc};
                h = x[3]&y[3] | y[3]&~r[3] | ~r[3]&x[3];
                c = x[7]&y[7] | y[7]&~r[7] | ~r[7]&x[7];
                v = x[7]&y[7]&~r[7] | ~x[7]&~y[7]&r[7];
                wc = 1; wz = 1; wnv = 1; wh = 1;
            end
            5'd2, 5'd3, 5'd4, 5'd5: begin
                r = x - y - {7'd0, cc};
                h = ~x[3]&y[3] | y[3]&r[3] | r[3]&~x[3];
                c = ~x[7]&y[7] | y[7]&r[7] | r[7]&~x[7];
                v = x[7]&~y[7]&~r[7] | ~x[7]&y[7]&r[7];
                wc = 1; wz = 1; wnv = 1; wh = 1;
                if (o == 5'd4 || o == 5'd5) w = 1'b0;
            end
            5'd6: begin r = x & y; v = 0; wz = 1; wnv = 1; end
            5'd7: begin r = x | y; v = 0; wz = 1; wnv = 1; end
            5'd8: begin r = x ^ y; v = 0; wz = 1; wnv = 1; end
            5'd9: begin r = 8'hFF - x; c = 1; v = 0; wc = 1; wz = 1; wnv = 1; end
            5'd10: begin
                r = 8'h00 - x; h = r[3] | x[3]; c = (r != 0); v = (r == 8'h80);
                wc = 1; wz = 1; wnv = 1; wh = 1;
            end
            5'd11: begin r = x + 1; v = (x == 8'h7F); wz = 1; wnv = 1; end
            5'd12: begin r = x - 1; v = (x == 8'h80); wz = 1; wnv = 1; end
            5'd13: begin r = {x[6:0], 1'b0}; c = x[7]; wc = 1; wz = 1; wnv = 1; end
            5'd14: begin r = {1'b0, x[7:1]}; c = x[0]; wc = 1; wz = 1; wnv = 1; end
            5'd15: begin r = {x[6:0], cin};  c = x[7]; wc = 1; wz = 1; wnv = 1; end
            5'd16: begin r = {cin, x[7:1]};  c = x[0]; wc = 1; wz = 1; wnv = 1; end
            5'd17: begin r = {x[7], x[7:1]}; c = x[0]; wc = 1; wz = 1; wnv = 1; end
            5'd18: r = {x[3:0], x[7:4]};
            default: begin r = x; w = 1'b0; end
        endcase
        if (o >= 5'd13 && o <= 5'd17) v = r[7] ^ c;
        if (wz) z = (o == 5'd3 || o == 5'd5) ? ((r == 0) && st[1]) : (r == 0);
        if (wnv) begin n = r[7]; s = n ^ v; end
        if (!wc) c = st[0];
        if (!wh) h = st[5];
        if (!wnv) begin v = st[3]; n = st[2]; s = st[4]; end
        return {w, r, 2'b00, h, s, v, n, z, c};
    endfunction

    task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_op(logic [4:0] o, logic [7:0] x, logic [7:0] y, logic cin, logic wen);
        logic [16:0] e;
        @(negedge clk);
        op = o; a = x; b = y; ci = cin; we = wen;
        e = model(o, x, y, cin, m_stat);
        #1;
        check(req_of(o), "result/wb", {7'd0, wb, result}, {7'd0, e[16], e[15:8]});
        @(posedge clk);
        #1;
        if (wen) m_stat = e[7:0];
        check(wen ? req_of(o) : "R12", "status", {8'd0, status}, {8'd0, m_stat});
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset status", {8'd0, status}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // Directed corners
        do_op(5'd0, 8'h7F, 8'h01, 1'b0, 1'b1);   // R2 overflow
        do_op(5'd0, 8'hFF, 8'h01, 1'b0, 1'b1);   // R2 carry, half, zero
        do_op(5'd1, 8'h0F, 8'h00, 1'b1, 1'b1);   // R2 carry-in into half
        do_op(5'd2, 8'h80, 8'h01, 1'b0, 1'b1);   // R3 signed overflow
        do_op(5'd4, 8'h10, 8'h20, 1'b0, 1'b1);   // R5 compare, no write-back
        // R4 chained compare: low byte differs, high byte equal -> Z stays 0
        do_op(5'd4, 8'h34, 8'h12, 1'b0, 1'b1);
        do_op(5'd5, 8'h56, 8'h56, 1'b0, 1'b1);
        // R4 both bytes equal -> Z stays 1
        do_op(5'd4, 8'h12, 8'h12, 1'b0, 1'b1);
        do_op(5'd3, 8'h56, 8'h56, 1'b0, 1'b1);
        do_op(5'd0, 8'h90, 8'h90, 1'b0, 1'b1);   // sets C for R6 hold
        do_op(5'd6, 8'hF0, 8'h0F, 1'b0, 1'b1);   // R6 zero, C held
        do_op(5'd9, 8'h00, 8'h00, 1'b0, 1'b1);   // R7 complement
        do_op(5'd10, 8'h80, 8'h00, 1'b0, 1'b1);  // R7 negate 0x80
        do_op(5'd10, 8'h00, 8'h00, 1'b0, 1'b1);  // R7 negate 0
        do_op(5'd11, 8'h7F, 8'h00, 1'b0, 1'b1);  // R8 increment overflow
        do_op(5'd12, 8'h80, 8'h00, 1'b0, 1'b1);  // R8 decrement overflow
        do_op(5'd17, 8'h81, 8'h00, 1'b0, 1'b1);  // R9 arithmetic shift
        do_op(5'd15, 8'h80, 8'h00, 1'b1, 1'b1);  // R9 rotate through carry
        do_op(5'd18, 8'hA5, 8'h00, 1'b0, 1'b1);  // R10 swap
        do_op(5'd0, 8'h7F, 8'h01, 1'b0, 1'b0);   // R12 no strobe
        do_op(5'd25, 8'h3C, 8'hFF, 1'b1, 1'b1);  // R13 unused code

        // Constrained random, R11 sign relation checked via status compare
        for (int i = 0; i < 600; i++) begin
            logic [4:0] ro;
            ro = ($urandom % 8 == 0) ? 5'(19 + $urandom % 13) : 5'($urandom % 19);
            do_op(ro, 8'($urandom), 8'($urandom), 1'($urandom), ($urandom % 4) != 0);
            if (i % 100 == 0) begin
                checks++;
                if (status[4] !== (status[2] ^ status[3])) begin
                    fails++;
                    $display("FAIL R11 sign: actual %b expected %b", status[4], status[2] ^ status[3]);
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule